// File: doc/BRIEF.md
# Debug Abstract Register-Access Engine

This block carries out register-access commands on behalf of an external debugger. The debugger sees three words on a small register port: a data word, a status word and a command word. When the debugger writes a command that asks for a transfer, the engine decodes the register number. It then sends a single read or write to one of two hart-side ports: one for general-purpose registers with a 5-bit address, and one for control/status registers with a 12-bit address. It waits for the matching response and then updates the data word and the status.

Each hart-side port has a request channel with a ready handshake and a separate response channel. Every request carries a transaction ID, and the matching response returns that ID along with an error flag. The debugger loads the data word before a write command. It polls the status word until the busy flag clears, then checks the error code and, after a read, collects the data word. Only 32-bit accesses and a single hart are handled.

Top module: `dbg_absreg_engine`

## Requirements
- R1: After reset, the status word, the data word and the command readback are all zero, and no request is valid on either hart-side port.
- R2: The register port selects the data word with dbg_sel 0, the status word with 1 and the command word with 2. The command word reads back as zero. In the status word, bit 12 is busy and bits 10:8 hold the error code: 0 none, 1 busy, 2 not supported, 3 exception. In the command word, bits 31:24 are the command type (0 means register access), bit 23 is reserved, bits 22:20 are the size (2 means 32 bits), bit 19 is reserved, bit 18 is postexec, bit 17 is transfer, bit 16 is write and bits 15:0 are the register number.
- R3: A register number from 0x1000 to 0x101F goes to the GPR port at address (regno - 0x1000). A register number from 0x0000 to 0x0FFF goes to the CSR port at address regno. At most one port has a valid request at any time.
- R4: A write command sends the current data word as write data with the write flag set. A read command that gets a non-error response loads the response data into the data word. In both cases the error code stays 0.
- R5: Busy reads 1 from the cycle after an accepted transfer command until the cycle after its response is taken. While a request waits for ready, its address, ID, write flag and data stay unchanged.
- R6: Issued requests carry IDs 0, 1, 2, … that wrap modulo 2^ID_W. A response whose ID differs from the outstanding request's ID is discarded without effect.
- R7: A matching response with the error flag set ends the command with error code 3 and leaves the data word unchanged.
- R8: A write to the command word or the data word while busy has no other effect, and it sets the error code to 1 if the code was 0.
- R9: A command with a nonzero type, a nonzero reserved bit, a size other than 2, or postexec set is rejected with error code 2 and no request. A command with transfer set whose register number lies in neither window is rejected the same way.
- R10: While the error code is nonzero, command writes are ignored. Writing the status word clears each error-code bit written as 1 and leaves the other bits unchanged.
- R11: A valid command with transfer clear finishes at once, with no request, no busy and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_valid | input | 1 | Register-port write strobe |
| dbg_write | input | 1 | 1 for a write, qualifies dbg_valid |
| dbg_sel | input | 2 | Register select: 0 data, 1 status, 2 command |
| dbg_wdata | input | 32 | Register-port write data |
| dbg_rdata | output | 32 | Selected register, combinational |
| gpr_req_valid | output | 1 | GPR request valid |
| gpr_req_ready | input | 1 | GPR request accepted |
| gpr_req_write | output | 1 | GPR request is a write |
| gpr_req_addr | output | GPR_AW | GPR number |
| gpr_req_wdata | output | DATA_W | GPR write data |
| gpr_req_id | output | ID_W | GPR request transaction ID |
| gpr_rsp_valid | input | 1 | GPR response valid |
| gpr_rsp_id | input | ID_W | GPR response transaction ID |
| gpr_rsp_err | input | 1 | GPR response error status |
| gpr_rsp_rdata | input | DATA_W | GPR read data |
| csr_req_valid | output | 1 | CSR request valid |
| csr_req_ready | input | 1 | CSR request accepted |
| csr_req_write | output | 1 | CSR request is a write |
| csr_req_addr | output | CSR_AW | CSR address |
| csr_req_wdata | output | DATA_W | CSR write data |
| csr_req_id | output | ID_W | CSR request transaction ID |
| csr_rsp_valid | input | 1 | CSR response valid |
| csr_rsp_id | input | ID_W | CSR response transaction ID |
| csr_rsp_err | input | 1 | CSR response error status |
| csr_rsp_rdata | input | DATA_W | CSR read data |

## Verification
The bench tests both ends of each register window: 0x1000, 0x101F, 0x0000 and 0x0FFF. An off-by-one in the window decode would route one of these to the wrong port or reject it. A stale-ID response is placed ahead of the real response. An engine that ignores IDs would end the read early and return the stale data. With a slow responder, the bench writes the data word and the command word mid-flight. A design that let these through would change the write data or start a second transaction instead of flagging a busy error. The bench also sends an error response and clears single error bits. A wrong priority between error setting and clearing would show up as a lost or stuck error code, or as a data word overwritten by a failed read.

// File: rtl/dbg_absreg_pkg.sv
package dbg_absreg_pkg;

   // register-port selects
   localparam logic [1:0] SEL_DATA0   = 2'd0;
   localparam logic [1:0] SEL_STATUS  = 2'd1;
   localparam logic [1:0] SEL_COMMAND = 2'd2;

   // status word layout
   localparam int STAT_BUSY_BIT = 12;
   localparam int STAT_ERR_LSB  = 8;

   // command word layout
   localparam int CMD_TYPE_LSB  = 24;
   localparam int CMD_RSV_HI    = 23;
   localparam int CMD_SIZE_LSB  = 20;
   localparam int CMD_RSV_LO    = 19;
   localparam int CMD_POSTEXEC  = 18;
   localparam int CMD_TRANSFER  = 17;
   localparam int CMD_WRITE     = 16;
   localparam logic [2:0] SIZE_WORD32 = 3'd2;

   // error codes
   localparam logic [2:0] ERR_NONE   = 3'd0;
   localparam logic [2:0] ERR_BUSY   = 3'd1;
   localparam logic [2:0] ERR_UNSUP  = 3'd2;
   localparam logic [2:0] ERR_EXCEPT = 3'd3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } eng_state_e;

   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_GPR = 2'd1,
      CMD_CSR = 2'd2,
      CMD_BAD = 2'd3
   } cmd_kind_e;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
   import dbg_absreg_pkg::*;
#(
   parameter int          GPR_AW   = 5,
   parameter int          CSR_AW   = 12,
   parameter logic [15:0] GPR_BASE = 16'h1000,
   parameter logic [15:0] CSR_BASE = 16'h0000
) (
   input  logic [31:0]       cmd_word,
   output cmd_kind_e         kind,
   output logic              is_write,
   output logic [GPR_AW-1:0] gpr_addr,
   output logic [CSR_AW-1:0] csr_addr
);

   logic [15:0] regno;
   logic [15:0] gpr_off;
   logic [15:0] csr_off;
   logic        gpr_hit;
   logic        csr_hit;
   logic        shape_bad;

   assign regno   = cmd_word[15:0];
   assign gpr_off = regno - GPR_BASE;
   assign csr_off = regno - CSR_BASE;
   assign gpr_hit = (regno >= GPR_BASE) && ((gpr_off >> GPR_AW) == 16'd0);
   assign csr_hit = (regno >= CSR_BASE) && ((csr_off >> CSR_AW) == 16'd0);

   assign shape_bad = (cmd_word[31:CMD_TYPE_LSB] != 8'd0)
                    || cmd_word[CMD_RSV_HI]
                    || (cmd_word[CMD_SIZE_LSB +: 3] != SIZE_WORD32)
                    || cmd_word[CMD_RSV_LO]
                    || cmd_word[CMD_POSTEXEC];

   assign is_write = cmd_word[CMD_WRITE];
   assign gpr_addr = gpr_off[GPR_AW-1:0];
   assign csr_addr = csr_off[CSR_AW-1:0];

   always_comb begin
      if (shape_bad)                       kind = CMD_BAD;
      else if (!cmd_word[CMD_TRANSFER])    kind = CMD_NOP;
      else if (gpr_hit)                    kind = CMD_GPR;
      else if (csr_hit)                    kind = CMD_CSR;
      else                                 kind = CMD_BAD;
   end

endmodule

// File: rtl/dbg_hart_port.sv
module dbg_hart_port #(
   parameter int AW  = 5,
   parameter int DW  = 32,
   parameter int IDW = 4
) (
   input  logic           sel,
   input  logic           issuing,
   input  logic           waiting,
   input  logic [AW-1:0]  txn_addr,
   input  logic           txn_write,
   input  logic [DW-1:0]  txn_wdata,
   input  logic [IDW-1:0] txn_id,
   output logic           req_valid,
   input  logic           req_ready,
   output logic           req_write,
   output logic [AW-1:0]  req_addr,
   output logic [DW-1:0]  req_wdata,
   output logic [IDW-1:0] req_id,
   input  logic           rsp_valid,
   input  logic [IDW-1:0] rsp_id,
   input  logic           rsp_err,
   input  logic [DW-1:0]  rsp_rdata,
   output logic           accepted,
   output logic           rsp_hit,
   output logic           rsp_fail,
   output logic [DW-1:0]  rsp_data
);

   assign req_valid = sel & issuing;
   assign req_write = txn_write;
   assign req_addr  = txn_addr;
   assign req_wdata = txn_wdata;
   assign req_id    = txn_id;
   assign accepted  = req_valid & req_ready;

   // a response counts only for the outstanding transaction on this port
   assign rsp_hit  = sel & waiting & rsp_valid & (rsp_id == txn_id);
   assign rsp_fail = rsp_err;
   assign rsp_data = rsp_rdata;

endmodule

// File: rtl/dbg_absreg_engine.sv
module dbg_absreg_engine
   import dbg_absreg_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          ID_W     = 4,
   parameter int          GPR_AW   = 5,
   parameter int          CSR_AW   = 12,
   parameter logic [15:0] GPR_BASE = 16'h1000,
   parameter logic [15:0] CSR_BASE = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_valid,
   input  logic              dbg_write,
   input  logic [1:0]        dbg_sel,
   input  logic [31:0]       dbg_wdata,
   output logic [31:0]       dbg_rdata,
   output logic              gpr_req_valid,
   input  logic              gpr_req_ready,
   output logic              gpr_req_write,
   output logic [GPR_AW-1:0] gpr_req_addr,
   output logic [DATA_W-1:0] gpr_req_wdata,
   output logic [ID_W-1:0]   gpr_req_id,
   input  logic              gpr_rsp_valid,
   input  logic [ID_W-1:0]   gpr_rsp_id,
   input  logic              gpr_rsp_err,
   input  logic [DATA_W-1:0] gpr_rsp_rdata,
   output logic              csr_req_valid,
   input  logic              csr_req_ready,
   output logic              csr_req_write,
   output logic [CSR_AW-1:0] csr_req_addr,
   output logic [DATA_W-1:0] csr_req_wdata,
   output logic [ID_W-1:0]   csr_req_id,
   input  logic              csr_rsp_valid,
   input  logic [ID_W-1:0]   csr_rsp_id,
   input  logic              csr_rsp_err,
   input  logic [DATA_W-1:0] csr_rsp_rdata
);

   localparam int ERR_W = 3;

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data_w
      $error("dbg_absreg_engine: DATA_W must be 32");
   end
   if (ID_W < 1 || ID_W > 16) begin : g_bad_id_w
      $error("dbg_absreg_engine: ID_W out of range");
   end
   if (GPR_AW < 1 || GPR_AW > 15) begin : g_bad_gpr_aw
      $error("dbg_absreg_engine: GPR_AW out of range");
   end
   if (CSR_AW < 1 || CSR_AW > 15) begin : g_bad_csr_aw
      $error("dbg_absreg_engine: CSR_AW out of range");
   end

   eng_state_e        state_q;
   logic              use_gpr_q;
   logic              txn_wr_q;
   logic [GPR_AW-1:0] gaddr_q;
   logic [CSR_AW-1:0] caddr_q;
   logic [ID_W-1:0]   id_ctr_q;
   logic [ID_W-1:0]   txn_id_q;
   logic [DATA_W-1:0] data0_q;
   logic [ERR_W-1:0]  cmderr_q;
   logic [ERR_W-1:0]  cmderr_d;

   logic              busy;
   logic              wr_data0;
   logic              wr_stat;
   logic              wr_cmd;
   logic              start_cmd;

   cmd_kind_e         dec_kind;
   logic              dec_write;
   logic [GPR_AW-1:0] dec_gaddr;
   logic [CSR_AW-1:0] dec_caddr;

   logic              g_acc, c_acc;
   logic              g_hit, c_hit;
   logic              g_fail, c_fail;
   logic [DATA_W-1:0] g_data, c_data;
   logic              accepted;
   logic              rsp_hit;
   logic              rsp_fail;
   logic [DATA_W-1:0] rsp_data;

   assign busy     = (state_q != ST_IDLE);
   assign wr_data0 = dbg_valid & dbg_write & (dbg_sel == SEL_DATA0);
   assign wr_stat  = dbg_valid & dbg_write & (dbg_sel == SEL_STATUS);
   assign wr_cmd   = dbg_valid & dbg_write & (dbg_sel == SEL_COMMAND);
   assign start_cmd = wr_cmd & ~busy & (cmderr_q == ERR_NONE)
                    & ((dec_kind == CMD_GPR) | (dec_kind == CMD_CSR));

   dbg_cmd_decode #(
      .GPR_AW   (GPR_AW),
      .CSR_AW   (CSR_AW),
      .GPR_BASE (GPR_BASE),
      .CSR_BASE (CSR_BASE)
   ) u_dec (
      .cmd_word (dbg_wdata),
      .kind     (dec_kind),
      .is_write (dec_write),
      .gpr_addr (dec_gaddr),
      .csr_addr (dec_caddr)
   );

   dbg_hart_port #(.AW(GPR_AW), .DW(DATA_W), .IDW(ID_W)) u_gpr (
      .sel       (use_gpr_q),
      .issuing   (state_q == ST_ISSUE),
      .waiting   (state_q == ST_WAIT),
      .txn_addr  (gaddr_q),
      .txn_write (txn_wr_q),
      .txn_wdata (data0_q),
      .txn_id    (txn_id_q),
      .req_valid (gpr_req_valid),
      .req_ready (gpr_req_ready),
      .req_write (gpr_req_write),
      .req_addr  (gpr_req_addr),
      .req_wdata (gpr_req_wdata),
      .req_id    (gpr_req_id),
      .rsp_valid (gpr_rsp_valid),
      .rsp_id    (gpr_rsp_id),
      .rsp_err   (gpr_rsp_err),
      .rsp_rdata (gpr_rsp_rdata),
      .accepted  (g_acc),
      .rsp_hit   (g_hit),
      .rsp_fail  (g_fail),
      .rsp_data  (g_data)
   );

   dbg_hart_port #(.AW(CSR_AW), .DW(DATA_W), .IDW(ID_W)) u_csr (
      .sel       (~use_gpr_q),
      .issuing   (state_q == ST_ISSUE),
      .waiting   (state_q == ST_WAIT),
      .txn_addr  (caddr_q),
      .txn_write (txn_wr_q),
      .txn_wdata (data0_q),
      .txn_id    (txn_id_q),
      .req_valid (csr_req_valid),
      .req_ready (csr_req_ready),
      .req_write (csr_req_write),
      .req_addr  (csr_req_addr),
      .req_wdata (csr_req_wdata),
      .req_id    (csr_req_id),
      .rsp_valid (csr_rsp_valid),
      .rsp_id    (csr_rsp_id),
      .rsp_err   (csr_rsp_err),
      .rsp_rdata (csr_rsp_rdata),
      .accepted  (c_acc),
      .rsp_hit   (c_hit),
      .rsp_fail  (c_fail),
      .rsp_data  (c_data)
   );

   assign accepted = g_acc | c_acc;
   assign rsp_hit  = g_hit | c_hit;
   assign rsp_fail = use_gpr_q ? g_fail : c_fail;
   assign rsp_data = use_gpr_q ? g_data : c_data;

   // error code: clear-on-one first, then any new error wins
   always_comb begin
      cmderr_d = cmderr_q;
      if (wr_stat)
         cmderr_d = cmderr_q & ~dbg_wdata[STAT_ERR_LSB +: ERR_W];
      if (busy && (wr_cmd || wr_data0) && cmderr_q == ERR_NONE)
         cmderr_d = ERR_BUSY;
      if (!busy && wr_cmd && cmderr_q == ERR_NONE && dec_kind == CMD_BAD)
         cmderr_d = ERR_UNSUP;
      if (rsp_hit && rsp_fail)
         cmderr_d = ERR_EXCEPT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         use_gpr_q <= 1'b0;
         txn_wr_q  <= 1'b0;
         gaddr_q   <= '0;
         caddr_q   <= '0;
         id_ctr_q  <= '0;
         txn_id_q  <= '0;
         data0_q   <= '0;
         cmderr_q  <= ERR_NONE;
      end else begin
         cmderr_q <= cmderr_d;
         if (wr_data0 && !busy)
            data0_q <= dbg_wdata;
         unique case (state_q)
            ST_IDLE: begin
               if (start_cmd) begin
                  state_q   <= ST_ISSUE;
                  use_gpr_q <= (dec_kind == CMD_GPR);
                  txn_wr_q  <= dec_write;
                  gaddr_q   <= dec_gaddr;
                  caddr_q   <= dec_caddr;
                  txn_id_q  <= id_ctr_q;
                  id_ctr_q  <= id_ctr_q + 1'b1;
               end
            end
            ST_ISSUE: begin
               if (accepted)
                  state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_hit) begin
                  state_q <= ST_IDLE;
                  if (!rsp_fail && !txn_wr_q)
                     data0_q <= rsp_data;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (dbg_sel)
         SEL_DATA0:  dbg_rdata = data0_q;
         SEL_STATUS: dbg_rdata = {19'd0, busy, 1'b0, cmderr_q, 8'd0};
         default:    dbg_rdata = 32'd0;
      endcase
   end

endmodule

// File: rtl/dbg_absreg_checker.sv
module dbg_absreg_checker #(
   parameter int DATA_W = 32,
   parameter int ID_W   = 4,
   parameter int GPR_AW = 5,
   parameter int CSR_AW = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              g_valid,
   input logic              g_ready,
   input logic              g_write,
   input logic [GPR_AW-1:0] g_addr,
   input logic [DATA_W-1:0] g_wdata,
   input logic [ID_W-1:0]   g_id,
   input logic              c_valid,
   input logic              c_ready,
   input logic              c_write,
   input logic [CSR_AW-1:0] c_addr,
   input logic [DATA_W-1:0] c_wdata,
   input logic [ID_W-1:0]   c_id,
   input logic              cmd_wr,
   input logic              busy,
   input logic [2:0]        cmderr,
   input logic              rsp_hit,
   input logic              rsp_fail
);

   assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({g_valid, c_valid}));

   assert_gpr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      g_valid && !g_ready |=> g_valid && $stable(g_addr) && $stable(g_id)
                              && $stable(g_wdata) && $stable(g_write));

   assert_csr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      c_valid && !c_ready |=> c_valid && $stable(c_addr) && $stable(c_id)
                              && $stable(c_wdata) && $stable(c_write));

   assert_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (g_valid || c_valid) |-> busy);

   assert_busy_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_wr && !rsp_hit |=> busy && (cmderr != 3'd0));

   assert_fail_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit && rsp_fail |=> (cmderr == 3'd3) && !busy);

   assert_err_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && (cmderr != 3'd0) && cmd_wr |=> !busy);

endmodule

bind dbg_absreg_engine dbg_absreg_checker #(
   .DATA_W (DATA_W),
   .ID_W   (ID_W),
   .GPR_AW (GPR_AW),
   .CSR_AW (CSR_AW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .g_valid  (gpr_req_valid),
   .g_ready  (gpr_req_ready),
   .g_write  (gpr_req_write),
   .g_addr   (gpr_req_addr),
   .g_wdata  (gpr_req_wdata),
   .g_id     (gpr_req_id),
   .c_valid  (csr_req_valid),
   .c_ready  (csr_req_ready),
   .c_write  (csr_req_write),
   .c_addr   (csr_req_addr),
   .c_wdata  (csr_req_wdata),
   .c_id     (csr_req_id),
   .cmd_wr   (wr_cmd),
   .busy     (busy),
   .cmderr   (cmderr_q),
   .rsp_hit  (rsp_hit),
   .rsp_fail (rsp_fail)
);

// File: tb/sim_dbg_absreg_engine.sv
`timescale 1ns/1ps
module sim_dbg_absreg_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_valid = 1'b0;
   logic        dbg_write = 1'b0;
   logic [1:0]  dbg_sel = 2'd0;
   logic [31:0] dbg_wdata = 32'd0;
   logic [31:0] dbg_rdata;

   logic        gpr_req_valid, gpr_req_write;
   logic [4:0]  gpr_req_addr;
   logic [31:0] gpr_req_wdata;
   logic [3:0]  gpr_req_id;
   logic        csr_req_valid, csr_req_write;
   logic [11:0] csr_req_addr;
   logic [31:0] csr_req_wdata;
   logic [3:0]  csr_req_id;

   logic        m_ready [2];
   logic        m_rv    [2];
   logic [3:0]  m_rid   [2];
   logic        m_rerr  [2];
   logic [31:0] m_rdat  [2];

   always #2 clk = ~clk;   // 250 MHz

   dbg_absreg_engine u0 (
      .clk(clk), .rst_n(rst_n),
      .dbg_valid(dbg_valid), .dbg_write(dbg_write), .dbg_sel(dbg_sel),
      .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
      .gpr_req_valid(gpr_req_valid), .gpr_req_ready(m_ready[0]),
      .gpr_req_write(gpr_req_write), .gpr_req_addr(gpr_req_addr),
      .gpr_req_wdata(gpr_req_wdata), .gpr_req_id(gpr_req_id),
      .gpr_rsp_valid(m_rv[0]), .gpr_rsp_id(m_rid[0]),
      .gpr_rsp_err(m_rerr[0]), .gpr_rsp_rdata(m_rdat[0]),
      .csr_req_valid(csr_req_valid), .csr_req_ready(m_ready[1]),
      .csr_req_write(csr_req_write), .csr_req_addr(csr_req_addr),
      .csr_req_wdata(csr_req_wdata), .csr_req_id(csr_req_id),
      .csr_rsp_valid(m_rv[1]), .csr_rsp_id(m_rid[1]),
      .csr_rsp_err(m_rerr[1]), .csr_rsp_rdata(m_rdat[1])
   );

   // ---------------- hart model ----------------
   logic [31:0] gmem [32];
   logic [31:0] cmem [4096];
   bit          pend [2];
   int          cnt  [2];
   bit          t_wr [2];
   int          t_adr[2];
   logic [3:0]  t_id [2];
   int          force_delay = -1;
   bit          inject_err = 1'b0;
   bit          inject_badid = 1'b0;
   int          n_req = 0;
   int          last_port, last_addr;
   bit          last_wr;
   logic [31:0] last_wdata;
   logic [3:0]  last_id;

   int n_chk = 0;
   int n_err = 0;

   initial begin
      for (int i = 0; i < 32; i++) gmem[i] = 32'h1000_0000 + i;
      for (int i = 0; i < 4096; i++) cmem[i] = 32'h2000_0000 + i;
      for (int p = 0; p < 2; p++) begin
         m_ready[p] = 1'b0; m_rv[p] = 1'b0; m_rid[p] = '0;
         m_rerr[p] = 1'b0; m_rdat[p] = '0; pend[p] = 1'b0; cnt[p] = 0;
      end
      forever begin
         @(negedge clk);
         for (int p = 0; p < 2; p++) begin
            m_rv[p] = 1'b0;
            m_rerr[p] = 1'b0;
            if (pend[p]) begin
               if (cnt[p] == 0) begin
                  m_rv[p] = 1'b1;
                  if (inject_badid) begin
                     m_rid[p] = t_id[p] + 4'd1;
                     m_rdat[p] = 32'hDEAD_BEEF;
                     inject_badid = 1'b0;
                     cnt[p] = 1;
                  end else begin
                     m_rid[p] = t_id[p];
                     m_rerr[p] = inject_err;
                     m_rdat[p] = inject_err ? 32'hBAD0_BAD0 :
                                 (p == 0 ? gmem[t_adr[p]] : cmem[t_adr[p]]);
                     if (t_wr[p] && !inject_err) begin
                        if (p == 0) gmem[t_adr[p]] = last_wdata;
                        else        cmem[t_adr[p]] = last_wdata;
                     end
                     inject_err = 1'b0;
                     pend[p] = 1'b0;
                  end
               end else begin
                  cnt[p] = cnt[p] - 1;
               end
            end
            m_ready[p] = ($urandom_range(0, 2) != 0);
            if (!pend[p] && m_ready[p] &&
                (p == 0 ? gpr_req_valid : csr_req_valid)) begin
               pend[p]  = 1'b1;
               cnt[p]   = (force_delay >= 0) ? force_delay : $urandom_range(0, 3);
               t_wr[p]  = (p == 0) ? gpr_req_write : csr_req_write;
               t_adr[p] = (p == 0) ? int'(gpr_req_addr) : int'(csr_req_addr);
               t_id[p]  = (p == 0) ? gpr_req_id : csr_req_id;
               last_port  = p;
               last_addr  = t_adr[p];
               last_wr    = t_wr[p];
               last_wdata = (p == 0) ? gpr_req_wdata : csr_req_wdata;
               last_id    = t_id[p];
               n_req++;
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      dbg_valid = 1'b1; dbg_write = 1'b1; dbg_sel = s; dbg_wdata = d;
      @(negedge clk);
      dbg_valid = 1'b0; dbg_write = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] s, output logic [31:0] d);
      dbg_sel = s;
      #1;
      d = dbg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      int          k;
      k = 0;
      reg_rd(2'd1, s);
      while (s[12] && k < 400) begin
         @(negedge clk);
         reg_rd(2'd1, s);
         k++;
      end
      check(!s[12], "R5 busy clears", s, 32'h0);
   endtask

   function automatic logic [31:0] mk_cmd(input logic [15:0] regno, input bit wr,
         input bit xfer, input logic [2:0] size, input bit pexec, input logic [7:0] typ);
      return {typ, 1'b0, size, 1'b0, pexec, xfer, wr, regno};
   endfunction

   logic [3:0] exp_id = 4'd0;

   task automatic do_access(input logic [15:0] regno, input bit wr, input logic [31:0] wd);
      int          eport, eaddr, n0;
      logic [31:0] old, s, d;
      eport = (regno >= 16'h1000) ? 0 : 1;
      eaddr = (eport == 0) ? int'(regno - 16'h1000) : int'(regno);
      old   = (eport == 0) ? gmem[eaddr] : cmem[eaddr];
      n0 = n_req;
      if (wr) reg_wr(2'd0, wd);
      reg_wr(2'd2, mk_cmd(regno, wr, 1'b1, 3'd2, 1'b0, 8'd0));
      reg_rd(2'd1, s);
      check(s[12] == 1'b1, "R5 busy after command", s, 32'h1000);
      wait_idle();
      reg_rd(2'd1, s);
      check(s[10:8] == 3'd0, "R4 no error", s, 32'h0);
      check(n_req == n0 + 1, "R3 one request", n_req, n0 + 1);
      check(last_port == eport && last_addr == eaddr, "R3 port/address",
            {last_port[15:0], last_addr[15:0]}, {eport[15:0], eaddr[15:0]});
      check(last_id == exp_id, "R6 transaction id", last_id, exp_id);
      exp_id = exp_id + 4'd1;
      check(last_wr == wr, "R4 write flag", last_wr, wr);
      reg_rd(2'd0, d);
      if (wr) begin
         check(last_wdata == wd, "R4 write data", last_wdata, wd);
         check(d == wd, "R4 data word kept", d, wd);
      end else begin
         check(d == old, "R4 read data", d, old);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      logic [31:0] s, d;
      int          n0;
      void'($urandom(32'd7331));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_rd(2'd1, s); check(s == 32'h0, "R1 status after reset", s, 32'h0);
      reg_rd(2'd0, d); check(d == 32'h0, "R1 data after reset", d, 32'h0);
      reg_rd(2'd2, d); check(d == 32'h0, "R2 command reads zero", d, 32'h0);
      check(!gpr_req_valid && !csr_req_valid, "R1 no request", 0, 0);

      // R3 window edges
      do_access(16'h1000, 1'b1, 32'hA5A5_0001);
      do_access(16'h101F, 1'b0, 32'h0);
      do_access(16'h0000, 1'b1, 32'h0C0C_0002);
      do_access(16'h0FFF, 1'b0, 32'h0);
      do_access(16'h1000, 1'b0, 32'h0);

      // R11 transfer clear
      n0 = n_req;
      reg_wr(2'd2, mk_cmd(16'h1005, 1'b0, 1'b0, 3'd2, 1'b0, 8'd0));
      reg_rd(2'd1, s); check(s == 32'h0, "R11 no busy no error", s, 32'h0);
      repeat (4) @(negedge clk);
      check(n_req == n0, "R11 no request", n_req, n0);

      // R9 unsupported shapes, R10 clear
      for (int k = 0; k < 5; k++) begin
         logic [31:0] c;
         case (k)
            0: c = mk_cmd(16'h1001, 1'b0, 1'b1, 3'd3, 1'b0, 8'd0);
            1: c = mk_cmd(16'h1001, 1'b0, 1'b1, 3'd2, 1'b1, 8'd0);
            2: c = mk_cmd(16'h1020, 1'b0, 1'b1, 3'd2, 1'b0, 8'd0);
            3: c = mk_cmd(16'h1001, 1'b0, 1'b1, 3'd2, 1'b0, 8'd1);
            default: c = mk_cmd(16'h1001, 1'b0, 1'b1, 3'd2, 1'b0, 8'd0) | 32'h0080_0000;
         endcase
         n0 = n_req;
         reg_wr(2'd2, c);
         reg_rd(2'd1, s); check(s == 32'h0000_0200, "R9 not supported", s, 32'h200);
         repeat (3) @(negedge clk);
         check(n_req == n0, "R9 no request", n_req, n0);
         reg_wr(2'd1, 32'h0000_0700);
         reg_rd(2'd1, s); check(s == 32'h0, "R10 clear on one", s, 32'h0);
      end

      // R7 error response
      reg_wr(2'd0, 32'h1234_5678);
      inject_err = 1'b1;
      reg_wr(2'd2, mk_cmd(16'h1003, 1'b0, 1'b1, 3'd2, 1'b0, 8'd0));
      wait_idle();
      exp_id = exp_id + 4'd1;
      reg_rd(2'd1, s); check(s[10:8] == 3'd3, "R7 exception code", s, 32'h300);
      reg_rd(2'd0, d); check(d == 32'h1234_5678, "R7 data unchanged", d, 32'h1234_5678);

      // R10 blocked while error
      n0 = n_req;
      reg_wr(2'd2, mk_cmd(16'h1004, 1'b0, 1'b1, 3'd2, 1'b0, 8'd0));
      reg_rd(2'd1, s); check(s == 32'h0000_0300, "R10 command ignored", s, 32'h300);
      repeat (4) @(negedge clk);
      check(n_req == n0, "R10 no request", n_req, n0);
      reg_wr(2'd1, 32'h0000_0100);
      reg_rd(2'd1, s); check(s == 32'h0000_0200, "R10 per-bit clear", s, 32'h200);
      reg_wr(2'd1, 32'h0000_0200);
      reg_rd(2'd1, s); check(s == 32'h0, "R10 fully cleared", s, 32'h0);

      // R8 writes while busy
      force_delay = 12;
      n0 = n_req;
      reg_wr(2'd0, 32'hAAAA_0007);
      reg_wr(2'd2, mk_cmd(16'h1007, 1'b1, 1'b1, 3'd2, 1'b0, 8'd0));
      reg_wr(2'd0, 32'hBBBB_0007);
      reg_wr(2'd2, mk_cmd(16'h0005, 1'b0, 1'b1, 3'd2, 1'b0, 8'd0));
      wait_idle();
      force_delay = -1;
      exp_id = exp_id + 4'd1;
      reg_rd(2'd1, s); check(s == 32'h0000_0100, "R8 busy error", s, 32'h100);
      check(n_req == n0 + 1, "R8 single request", n_req, n0 + 1);
      check(last_wdata == 32'hAAAA_0007, "R8 write data kept", last_wdata, 32'hAAAA_0007);
      reg_rd(2'd0, d); check(d == 32'hAAAA_0007, "R8 data write ignored", d, 32'hAAAA_0007);
      reg_wr(2'd1, 32'h0000_0700);

      // R6 stale ID discarded
      inject_badid = 1'b1;
      do_access(16'h1009, 1'b0, 32'h0);
      inject_badid = 1'b1;
      do_access(16'h0123, 1'b0, 32'h0);

      // random mix
      for (int it = 0; it < 48; it++) begin
         logic [15:0] r;
         r = ($urandom_range(0, 1) != 0) ? (16'h1000 + 16'($urandom_range(0, 31)))
                                         : 16'($urandom_range(0, 4095));
         do_access(r, ($urandom_range(0, 1) != 0), $urandom);
      end

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule